// File: doc/BRIEF.md
# Speculative Access Attribute Gate

This block sits between a load/store issue stage and the data cache controller. Each incoming request carries an address, a read/write flag, a speculative flag and four memory attribute bits: write-through (`w`), caching-inhibited (`i`), coherence-required (`m`) and guarded (`g`). For each request the block decides three things:

- whether the cache is consulted at all;
- whether the access reaches external memory;
- whether the external request is flagged as global for coherence.

The gate also withholds any access that must not be performed ahead of the program. A speculative store is never released early, whatever its attributes. A speculative load from guarded memory is likewise held. Either kind waits in the single slot until a `commit` or a `flush` arrives. A speculative load from unguarded memory passes straight through, because reading such memory early is harmless.

Requests enter and leave through valid/ready handshakes. The slot accepts a new request only when it is empty. Routing decisions are registered, so a released request shows its flags one cycle after it is accepted. A held request shows them one cycle after its commit.

Top module: `spec_attr_gate`

## Requirements
- R1: After reset, `req_ready` is 1 and both `out_valid` and `attr_err` are 0.
- R2: A request that needs no hold raises `out_valid` in the cycle after it is accepted. No hold is needed when it is non-speculative, or when it is a speculative load (`req_write`=0) with `req_g`=0.
- R3: A speculative store, or a speculative load with `req_g`=1, is held. While held, `out_valid` stays 0 and `req_ready` stays 0 for as long as no commit arrives.
- R4: While a request is held, `commit`=1 with `flush`=0 releases it. `out_valid` is 1 in the following cycle.
- R5: While a request is held, `flush`=1 discards it, even if `commit` is also 1. `out_valid` never rises for that request, and `req_ready` is 1 in the following cycle.
- R6: `out_use_cache` is 1 exactly when the effective inhibit bit is 0. A committed guarded load with `i`=0 therefore uses the cache.
- R7: `out_ext` is 1 when the effective inhibit bit is 1. It is also 1 for a store whose effective write-through bit is 1. It is 0 otherwise, so a copy-back store or a cacheable load stays local.
- R8: `out_global` equals the request's `m` bit.
- R9: The combination `w`=1 with `i`=1 is treated as effective inhibit 1 and effective write-through 0. In that case `attr_err` is 1 for exactly the one cycle after acceptance. Every other attribute combination leaves `attr_err` at 0.
- R10: `out_addr` and `out_write` equal the accepted request's values. All output fields stay stable while `out_valid`=1 and `out_ready`=0. `out_valid` falls in the cycle after `out_ready`=1.
- R11: `commit` and `flush` have no effect while the slot is empty or is presenting a released request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Incoming request present |
| req_ready | output | 1 | Slot empty, request can be taken |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_spec | input | 1 | Request is still speculative |
| req_w | input | 1 | Write-through attribute |
| req_i | input | 1 | Caching-inhibited attribute |
| req_m | input | 1 | Coherence-required attribute |
| req_g | input | 1 | Guarded attribute |
| commit | input | 1 | Held request is now non-speculative |
| flush | input | 1 | Held request is cancelled |
| out_valid | output | 1 | Routed request present |
| out_ready | input | 1 | Downstream takes the routed request |
| out_addr | output | ADDR_W | Routed address |
| out_write | output | 1 | Routed read/write flag |
| out_use_cache | output | 1 | Cache lookup is performed |
| out_ext | output | 1 | Access goes to external memory |
| out_global | output | 1 | External request flagged global |
| attr_err | output | 1 | One-cycle pulse for the conflicting `w`=1, `i`=1 combination |

## Verification
A slot state that is wrong shows up at the ports within one cycle of the event that should have moved it. It appears either as `out_valid` rising for a held or flushed request, or as `req_ready` staying low after a flush. A faulty routing decision is visible on the flags in the first cycle `out_valid` is high. The sweep covers every combination of read/write, speculation and the four attribute bits. Each held case is released by commit, by flush, and by both asserted together, so a wrong priority or a lost hold cannot pass unnoticed.

// File: rtl/spec_gate_pkg.sv
// Shared types for the speculative access attribute gate.
package spec_gate_pkg;

    // Occupancy of the single request slot.
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_HELD  = 2'd1,
        SLOT_SEND  = 2'd2
    } slot_state_e;

    // Routing decision carried with a request.
    typedef struct packed {
        logic use_cache;
        logic ext;
        logic glob;
    } route_t;

endpackage

// File: rtl/sg_attr_decode.sv
// Combinational routing decode from the W/I/M attribute bits and the
// operation type. Assumes the conflicting W=1,I=1 pair is resolved as
// inhibited, non-write-through; it reports the conflict separately.
module sg_attr_decode
    import spec_gate_pkg::*;
(
    input  logic   is_write,
    input  logic   attr_w,
    input  logic   attr_i,
    input  logic   attr_m,
    output route_t route,
    output logic   conflict
);

    logic inh_eff;
    logic wt_eff;

    // Resolve effective attributes and derive the route.
    always_comb begin
        conflict        = attr_w & attr_i;
        inh_eff         = attr_i;
        wt_eff          = attr_w & ~attr_i;
        route.use_cache = ~inh_eff;
        route.ext       = inh_eff | (is_write & wt_eff);
        route.glob      = attr_m;
    end

endmodule

// File: rtl/sg_slot_ctrl.sv
// Single-slot occupancy control. Decides on acceptance whether a request
// must wait for commit (speculative stores and speculative guarded loads),
// releases it on commit, drops it on flush (flush wins). Commit and flush
// are only observed while a request is held.
module sg_slot_ctrl
    import spec_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_spec,
    input  logic req_write,
    input  logic req_guard,
    input  logic commit,
    input  logic flush,
    input  logic out_ready,
    output logic req_ready,
    output logic out_valid,
    output logic accept
);

    slot_state_e state_q;
    slot_state_e state_d;
    logic        need_hold;

    // Handshake outputs and hold decision.
    always_comb begin
        req_ready = (state_q == SLOT_EMPTY);
        out_valid = (state_q == SLOT_SEND);
        accept    = req_valid & req_ready;
        need_hold = req_spec & (req_write | req_guard);
    end

    // Next-state selection for the slot.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (accept) state_d = need_hold ? SLOT_HELD : SLOT_SEND;
            SLOT_HELD: begin
                if (flush)       state_d = SLOT_EMPTY;
                else if (commit) state_d = SLOT_SEND;
            end
            SLOT_SEND:  if (out_ready) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    // Slot state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    assert_held_no_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_HELD && !commit) |=> !out_valid);

    assert_spec_store_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_spec && req_write) |=> (!out_valid && !req_ready));

    assert_commit_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_HELD && commit && !flush) |=> out_valid);

    assert_flush_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_HELD && flush) |=> (!out_valid && req_ready));

    assert_unheld_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_spec) |=> out_valid);

endmodule

// File: rtl/sg_payload_reg.sv
// Captures address, direction and routing decision when a request is
// accepted and presents them until the slot is refilled. Raises a one-cycle
// conflict pulse after accepting a W=1,I=1 request. Assumes accept can only
// occur while the slot is empty.
module sg_payload_reg
    import spec_gate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              out_valid,
    input  logic              out_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  route_t            in_route,
    input  logic              in_conflict,
    output logic [ADDR_W-1:0] q_addr,
    output logic              q_write,
    output route_t            q_route,
    output logic              err_pulse
);

    // Payload capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_write <= 1'b0;
            q_route <= '0;
        end else if (accept) begin
            q_addr  <= in_addr;
            q_write <= in_write;
            q_route <= in_route;
        end
    end

    // One-cycle attribute conflict pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err_pulse <= 1'b0;
        else        err_pulse <= accept & in_conflict;
    end

    assert_out_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> ($stable(q_addr) && $stable(q_write) && $stable(q_route)));

    assert_err_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

endmodule

// File: rtl/spec_attr_gate.sv
// Top of the speculative access attribute gate. Holds one request, keeps
// speculative stores and speculative guarded loads back until commit, and
// routes each released request by its W/I/M attributes. Assumes downstream
// honours the valid/ready handshake on the routed output.
module spec_attr_gate
    import spec_gate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_spec,
    input  logic              req_w,
    input  logic              req_i,
    input  logic              req_m,
    input  logic              req_g,
    input  logic              commit,
    input  logic              flush,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write,
    output logic              out_use_cache,
    output logic              out_ext,
    output logic              out_global,
    output logic              attr_err
);

    route_t dec_route;
    route_t held_route;
    logic   dec_conflict;
    logic   accept;

    sg_attr_decode u_decode (
        .is_write (req_write),
        .attr_w   (req_w),
        .attr_i   (req_i),
        .attr_m   (req_m),
        .route    (dec_route),
        .conflict (dec_conflict)
    );

    sg_slot_ctrl u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_spec  (req_spec),
        .req_write (req_write),
        .req_guard (req_g),
        .commit    (commit),
        .flush     (flush),
        .out_ready (out_ready),
        .req_ready (req_ready),
        .out_valid (out_valid),
        .accept    (accept)
    );

    sg_payload_reg #(.ADDR_W(ADDR_W)) u_payload (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .in_addr     (req_addr),
        .in_write    (req_write),
        .in_route    (dec_route),
        .in_conflict (dec_conflict),
        .q_addr      (out_addr),
        .q_write     (out_write),
        .q_route     (held_route),
        .err_pulse   (attr_err)
    );

    // Route fields to output ports.
    always_comb begin
        out_use_cache = held_route.use_cache;
        out_ext       = held_route.ext;
        out_global    = held_route.glob;
    end

    assert_inhibit_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_i) |=> !out_use_cache);

    assert_global_follows_m_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_global == $past(req_m)));

    assert_wt_store_external_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && req_w) |=> out_ext);

    assert_conflict_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (attr_err == $past(req_w && req_i)));

endmodule

// File: tb/spec_attr_gate_tb.sv
`timescale 1ns/1ps
module spec_attr_gate_tb;

    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic              req_spec = 1'b0;
    logic              req_w = 1'b0;
    logic              req_i = 1'b0;
    logic              req_m = 1'b0;
    logic              req_g = 1'b0;
    logic              commit = 1'b0;
    logic              flush = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [ADDR_W-1:0] out_addr;
    logic              out_write;
    logic              out_use_cache;
    logic              out_ext;
    logic              out_global;
    logic              attr_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spec_attr_gate #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_spec(req_spec),
        .req_w(req_w), .req_i(req_i), .req_m(req_m), .req_g(req_g),
        .commit(commit), .flush(flush),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_write(out_write),
        .out_use_cache(out_use_cache), .out_ext(out_ext),
        .out_global(out_global), .attr_err(attr_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // action: 0 commit, 1 flush, 2 commit and flush together
    task automatic run_case(input bit wr, input bit sp, input logic [3:0] attr,
                            input int action, input logic [ADDR_W-1:0] addr);
        bit a_w, a_i, a_m, a_g, hold, e_use, e_ext, e_wt;
        a_w = attr[3]; a_i = attr[2]; a_m = attr[1]; a_g = attr[0];
        hold  = sp && (wr || a_g);
        e_wt  = a_w && !a_i;
        e_use = !a_i;
        e_ext = a_i || (wr && e_wt);

        chk("R10 ready before accept", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_spec = sp;
        req_w = a_w; req_i = a_i; req_m = a_m; req_g = a_g;
        step();
        req_valid = 1'b0;
        chk("R9 conflict pulse", 32'(attr_err), 32'(a_w && a_i));

        if (hold) begin
            chk("R3 held output idle", 32'(out_valid), 32'd0);
            chk("R3 held ready low", 32'(req_ready), 32'd0);
            step();
            chk("R3 still held", 32'(out_valid), 32'd0);
            chk("R9 pulse one cycle", 32'(attr_err), 32'd0);
            commit = (action != 1);
            flush  = (action != 0);
            step();
            commit = 1'b0; flush = 1'b0;
            if (action != 0) begin
                chk("R5 flushed no output", 32'(out_valid), 32'd0);
                chk("R5 slot freed", 32'(req_ready), 32'd1);
                step();
                chk("R5 stays discarded", 32'(out_valid), 32'd0);
                return;
            end
            chk("R4 released on commit", 32'(out_valid), 32'd1);
        end else begin
            chk("R2 issue next cycle", 32'(out_valid), 32'd1);
        end

        chk("R6 use_cache", 32'(out_use_cache), 32'(e_use));
        chk("R7 external", 32'(out_ext), 32'(e_ext));
        chk("R8 global", 32'(out_global), 32'(a_m));
        chk("R10 address", 32'(out_addr), 32'(addr));
        chk("R10 direction", 32'(out_write), 32'(wr));

        // stall downstream and pulse commit/flush, which must be ignored
        commit = 1'b1; flush = 1'b1;
        step();
        commit = 1'b0; flush = 1'b0;
        chk("R11 valid kept despite flush", 32'(out_valid), 32'd1);
        chk("R10 address stable", 32'(out_addr), 32'(addr));
        chk("R10 ext stable", 32'(out_ext), 32'(e_ext));
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        chk("R10 drained", 32'(out_valid), 32'd0);
        chk("R10 ready again", 32'(req_ready), 32'd1);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog all: actual cycles=%0d expected below 100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ready", 32'(req_ready), 32'd1);
        chk("R1 reset out_valid", 32'(out_valid), 32'd0);
        chk("R1 reset attr_err", 32'(attr_err), 32'd0);

        // R11: commit/flush while empty must not disturb a later hold
        commit = 1'b1; flush = 1'b1;
        step();
        commit = 1'b0; flush = 1'b0;
        chk("R11 empty ignores flush", 32'(req_ready), 32'd1);
        chk("R11 empty no output", 32'(out_valid), 32'd0);

        for (int wr = 0; wr < 2; wr++) begin
            for (int sp = 0; sp < 2; sp++) begin
                for (int a = 0; a < 16; a++) begin
                    bit hold;
                    hold = (sp == 1) && ((wr == 1) || a[0]);
                    for (int act = 0; act < (hold ? 3 : 1); act++) begin
                        run_case(wr[0], sp[0], a[3:0], act,
                                 ADDR_W'(16'h1000 + wr * 16'h0400 + sp * 16'h0100 + a * 16'h0010 + act));
                    end
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule